// File: doc/BRIEF.md
# Fast-Control Status History Logger

This block watches three fast-control status flags (busy, warn and out-of-sync) and keeps a timestamped history of their transitions. A free-running clock counter supplies the time base. For every flag the block stores the counter value at which the flag went high. It stores the value at which it went low again in the same entry, so each entry is an assert/negate pair. A programmable limit sets how many pairs each flag keeps. Once a flag has stored that many pairs it stops recording and raises its full indicator. Independently of the history, each flag has a cycle counter that totals how long the flag has been high. The counter sticks at its maximum.

Software or a neighbouring controller reads the history through a combinational register read port: an address selects a flag, a field kind and an entry index. A clear pulse restarts all three histories and totals without disturbing the time base, so timestamps taken before and after a clear share one time axis.

Top module: `fch_hist_logger`

## Requirements
- R1: After reset the timestamp counter starts at 0 and advances by one on every clock, wrapping at its width. A clear does not disturb it.
- R2: A flag sampled high at a clock edge after being sampled low at the previous edge is a rising event. If the flag is not full, the counter value at that edge is written as the rising time of entry N, where N is the number of completed pairs.
- R3: A falling event (high at the previous edge, low now) that follows a recorded rising event writes the counter value as the falling time of the same entry. It then increments the completed-pair count by one.
- R4: A flag is full when its completed-pair count is at least the effective limit, where the effective limit is the minimum of limit_i and DEPTH. While full, rising events store nothing, and the count does not move. full_o reflects the current limit_i combinationally, so a limit of 0 makes the flag full at once.
- R5: The total for each flag increases by one for every clock edge at which the flag is sampled high, whether or not the flag is full.
- R6: A total that has reached its all-ones maximum stays there instead of wrapping.
- R7: A clear sampled at an edge sets the count, the open-pair state and the total of every flag to zero. Edges seen in that same cycle record nothing and add nothing. Stored timestamps are not erased.
- R8: rd_data_o follows rd_addr_i in the same cycle. Address bits [7:6] select the flag (0 busy, 1 warn, 2 out-of-sync, 3 reads zero). Bits [5:4] select the field (0 rising time, 1 falling time, 2 total, 3 completed-pair count). Bits [3:0] select the entry for fields 0 and 1. Totals and counts are zero-extended.
- R9: The three flags are recorded independently: events on one flag never change the entries, count, total or full state of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flags_i | input | 3 | Status flags: bit 0 busy, bit 1 warn, bit 2 out-of-sync |
| clear_i | input | 1 | Restart histories and totals |
| limit_i | input | 5 | Number of pairs to keep per flag (clamped to DEPTH) |
| rd_addr_i | input | 8 | Read address: flag, field kind, entry index |
| rd_data_o | output | 32 | Read data for rd_addr_i |
| full_o | output | 3 | Per-flag full indicator |

## Verification
The hardest situations to reach from the ports are those where a change of control collides with an event. One is a clear arriving in the same cycle as a rising or falling edge. Another is limit_i being lowered or raised while a pair is half open, so that the flag becomes full with an entry still waiting for its negation. The stimulus walks through phases with different toggle rates and limits, including values above DEPTH and zero. Sparse random clears are spread over fast-toggling flags, so these collisions occur many times. One phase holds a flag high long enough to drive its narrowed total into saturation.

// File: rtl/fch_pkg.sv
package fch_pkg;

    localparam int NUM_FLAGS = 3;

    typedef enum logic [1:0] {
        KIND_RISE  = 2'd0,
        KIND_FALL  = 2'd1,
        KIND_TOTAL = 2'd2,
        KIND_COUNT = 2'd3
    } fch_kind_e;

endpackage

// File: rtl/fch_tstamp.sv
module fch_tstamp #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts_o
);

    typedef struct packed {
        logic [TS_W-1:0] ts;
    } ts_state_t;

    ts_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ts = st_q.ts + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ts_o = st_q.ts;

endmodule

// File: rtl/fch_channel.sv
module fch_channel #(
    parameter int TS_W  = 32,
    parameter int DEPTH = 16,
    parameter int TOT_W = 32,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flag_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic [TS_W-1:0]  ts_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [TS_W-1:0]  rd_rise_o,
    output logic [TS_W-1:0]  rd_fall_o,
    output logic [TOT_W-1:0] total_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o
);

    localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);
    localparam logic [TOT_W-1:0] TOT_MAX  = {TOT_W{1'b1}};

    typedef struct packed {
        logic             prev;
        logic             open;
        logic [CNT_W-1:0] cnt;
        logic [TOT_W-1:0] tot;
    } ch_state_t;

    ch_state_t       st_d, st_q;
    logic [TS_W-1:0] rise_d [DEPTH];
    logic [TS_W-1:0] rise_q [DEPTH];
    logic [TS_W-1:0] fall_d [DEPTH];
    logic [TS_W-1:0] fall_q [DEPTH];

    logic             rise_ev;
    logic             fall_ev;
    logic [CNT_W-1:0] lim_eff;
    logic             full_w;
    logic [IDX_W-1:0] wr_idx;

    assign rise_ev = flag_i & ~st_q.prev;
    assign fall_ev = ~flag_i & st_q.prev;
    assign lim_eff = (limit_i > DEPTH_C) ? DEPTH_C : limit_i;
    assign full_w  = (st_q.cnt >= lim_eff);
    assign wr_idx  = st_q.cnt[IDX_W-1:0];

    always_comb begin
        st_d   = st_q;
        rise_d = rise_q;
        fall_d = fall_q;
        if (clear_i) begin
            st_d.cnt  = '0;
            st_d.open = 1'b0;
            st_d.tot  = '0;
        end else begin
            if (rise_ev && !full_w) begin
                rise_d[wr_idx] = ts_i;
                st_d.open      = 1'b1;
            end
            if (fall_ev && st_q.open) begin
                fall_d[wr_idx] = ts_i;
                st_d.cnt       = st_q.cnt + 1'b1;
                st_d.open      = 1'b0;
            end
            if (flag_i && (st_q.tot != TOT_MAX)) begin
                st_d.tot = st_q.tot + 1'b1;
            end
        end
        st_d.prev = flag_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                rise_q[i] <= '0;
                fall_q[i] <= '0;
            end
        end else begin
            st_q   <= st_d;
            rise_q <= rise_d;
            fall_q <= fall_d;
        end
    end

    assign rd_rise_o = rise_q[rd_idx_i];
    assign rd_fall_o = fall_q[rd_idx_i];
    assign total_o   = st_q.tot;
    assign count_o   = st_q.cnt;
    assign full_o    = full_w;

endmodule

// File: rtl/fch_rdmux.sv
module fch_rdmux
    import fch_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int TOT_W = 32,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5
) (
    input  logic [IDX_W+3:0]                  addr_i,
    input  logic [NUM_FLAGS-1:0][TS_W-1:0]    rise_i,
    input  logic [NUM_FLAGS-1:0][TS_W-1:0]    fall_i,
    input  logic [NUM_FLAGS-1:0][TOT_W-1:0]   tot_i,
    input  logic [NUM_FLAGS-1:0][CNT_W-1:0]   cnt_i,
    output logic [TS_W-1:0]                   data_o
);

    logic [1:0] sel_ch;
    fch_kind_e  sel_kind;

    assign sel_ch   = addr_i[IDX_W+3:IDX_W+2];
    assign sel_kind = fch_kind_e'(addr_i[IDX_W+1:IDX_W]);

    always_comb begin
        data_o = '0;
        for (int c = 0; c < NUM_FLAGS; c++) begin
            if (sel_ch == 2'(c)) begin
                case (sel_kind)
                    KIND_RISE:  data_o = rise_i[c];
                    KIND_FALL:  data_o = fall_i[c];
                    KIND_TOTAL: data_o = TS_W'(tot_i[c]);
                    default:    data_o = TS_W'(cnt_i[c]);
                endcase
            end
        end
    end

endmodule

// File: rtl/fch_hist_logger.sv
module fch_hist_logger
    import fch_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int DEPTH = 16,
    parameter int TOT_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [2:0]                  flags_i,
    input  logic                        clear_i,
    input  logic [$clog2(DEPTH+1)-1:0]  limit_i,
    input  logic [$clog2(DEPTH)+3:0]    rd_addr_i,
    output logic [TS_W-1:0]             rd_data_o,
    output logic [2:0]                  full_o
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [TS_W-1:0]                 ts_w;
    logic [NUM_FLAGS-1:0][TS_W-1:0]  ch_rise;
    logic [NUM_FLAGS-1:0][TS_W-1:0]  ch_fall;
    logic [NUM_FLAGS-1:0][TOT_W-1:0] ch_tot;
    logic [NUM_FLAGS-1:0][CNT_W-1:0] ch_cnt;

    fch_tstamp #(.TS_W(TS_W)) tstamp_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ts_o  (ts_w)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_ch
        fch_channel #(
            .TS_W  (TS_W),
            .DEPTH (DEPTH),
            .TOT_W (TOT_W),
            .IDX_W (IDX_W),
            .CNT_W (CNT_W)
        ) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .flag_i    (flags_i[g]),
            .clear_i   (clear_i),
            .limit_i   (limit_i),
            .ts_i      (ts_w),
            .rd_idx_i  (rd_addr_i[IDX_W-1:0]),
            .rd_rise_o (ch_rise[g]),
            .rd_fall_o (ch_fall[g]),
            .total_o   (ch_tot[g]),
            .count_o   (ch_cnt[g]),
            .full_o    (full_o[g])
        );
    end

    fch_rdmux #(
        .TS_W  (TS_W),
        .TOT_W (TOT_W),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) rdmux_i (
        .addr_i (rd_addr_i),
        .rise_i (ch_rise),
        .fall_i (ch_fall),
        .tot_i  (ch_tot),
        .cnt_i  (ch_cnt),
        .data_o (rd_data_o)
    );

endmodule

// File: rtl/fch_checker.sv
module fch_checker #(
    parameter int TS_W  = 32,
    parameter int DEPTH = 16,
    parameter int TOT_W = 32,
    parameter int CNT_W = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  clear_i,
    input logic [TS_W-1:0]       ts,
    input logic [2:0][CNT_W-1:0] cnt,
    input logic [2:0][TOT_W-1:0] tot
);

    localparam logic [TOT_W-1:0] TOT_MAX = {TOT_W{1'b1}};
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    // R1
    ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ts == TS_W'($past(ts) + 1'b1));

    for (genvar g = 0; g < 3; g++) begin : g_chk
        // R7
        clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clear_i |=> (cnt[g] == '0) && (tot[g] == '0));

        // R6
        tot_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clear_i && tot[g] == TOT_MAX) |=> tot[g] == TOT_MAX);

        // R5
        tot_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clear_i |=> tot[g] >= $past(tot[g]));

        // R3
        cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clear_i |=> (cnt[g] == $past(cnt[g])) ||
                         (cnt[g] == CNT_W'($past(cnt[g]) + 1'b1)));

        // R4
        cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[g] <= DEPTH_C);
    end

endmodule

bind fch_hist_logger fch_checker #(
    .TS_W  (TS_W),
    .DEPTH (DEPTH),
    .TOT_W (TOT_W),
    .CNT_W (CNT_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear_i),
    .ts      (ts_w),
    .cnt     (ch_cnt),
    .tot     (ch_tot)
);

// File: tb/fch_hist_logger_tb_top.sv
module fch_hist_logger_tb_top;

    localparam int TS_W  = 32;
    localparam int DEPTH = 16;
    localparam int TOT_W = 6;
    localparam int TMAX  = 63;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  flags;
    logic        clear;
    logic [4:0]  limit;
    logic [7:0]  rd_addr;
    logic [31:0] rd_data;
    logic [2:0]  full;

    always #10 clk = ~clk;

    fch_hist_logger #(.TS_W(TS_W), .DEPTH(DEPTH), .TOT_W(TOT_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags_i   (flags),
        .clear_i   (clear),
        .limit_i   (limit),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .full_o    (full)
    );

    // behavioural reference
    logic [31:0] m_ts;
    int          m_cnt  [3];
    bit          m_open [3];
    bit          m_prev [3];
    int          m_tot  [3];
    logic [31:0] m_rise [3][DEPTH];
    logic [31:0] m_fall [3][DEPTH];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;
    bit          after_clear = 1'b0;

    task automatic model_step(input logic [2:0] f, input logic clr, input int lim);
        int eff;
        eff = (lim > DEPTH) ? DEPTH : lim;
        for (int i = 0; i < 3; i++) begin
            if (clr) begin
                m_cnt[i] = 0; m_open[i] = 0; m_tot[i] = 0;
            end else begin
                if (f[i] && !m_prev[i] && m_cnt[i] < eff) begin
                    m_rise[i][m_cnt[i]] = m_ts; m_open[i] = 1;
                end
                if (!f[i] && m_prev[i] && m_open[i]) begin
                    m_fall[i][m_cnt[i]] = m_ts; m_cnt[i]++; m_open[i] = 0;
                end
                if (f[i] && m_tot[i] < TMAX) m_tot[i]++;
            end
            m_prev[i] = f[i];
        end
        m_ts = m_ts + 32'd1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%0h actual=%0h expected=%0h", tag, rd_addr, act, exp);
        end
    endtask

    task automatic compare_all();
        int ch, kind, idx, eff;
        logic [31:0] exp;
        string tag;
        ch = int'(rd_addr[7:6]); kind = int'(rd_addr[5:4]); idx = int'(rd_addr[3:0]);
        if (ch == 3) begin
            exp = 0; tag = "R8 unused flag slot";
        end else begin
            case (kind)
                0: begin exp = m_rise[ch][idx];
                         tag = (ch != 0) ? "R9 rising time" : "R2 rising time (R1 time base)"; end
                1: begin exp = m_fall[ch][idx]; tag = "R3 falling time"; end
                2: begin exp = 32'(m_tot[ch]);
                         tag = (m_tot[ch] == TMAX) ? "R6 saturated total" :
                               (after_clear ? "R7 total after clear" : "R5 total"); end
                default: begin exp = 32'(m_cnt[ch]);
                         tag = after_clear ? "R7 count after clear" : "R4 pair count"; end
            endcase
        end
        check(tag, rd_data, exp);
        eff = (int'(limit) > DEPTH) ? DEPTH : int'(limit);
        for (int i = 0; i < 3; i++) begin
            check("R4 full flag", {31'd0, full[i]}, {31'd0, m_cnt[i] >= eff});
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] f_prev;
        logic       c_prev;
        int         l_prev;
        int         tog;
        rst_n = 1'b0; flags = '0; clear = 1'b0; limit = 5'd4; rd_addr = '0;
        m_ts = 0;
        for (int i = 0; i < 3; i++) begin
            m_cnt[i] = 0; m_open[i] = 0; m_prev[i] = 0; m_tot[i] = 0;
            for (int j = 0; j < DEPTH; j++) begin m_rise[i][j] = 0; m_fall[i][j] = 0; end
        end
        repeat (3) @(negedge clk);
        // reset state: R1 (zeroed time base), R4 count and R5 total start at zero
        for (int a = 0; a < 256; a += 13) begin
            rd_addr = 8'(a); #1; compare_all();
        end
        rst_n = 1'b1;
        f_prev = flags; c_prev = clear; l_prev = int'(limit);
        for (int c = 0; c < 2400; c++) begin
            @(negedge clk);
            model_step(f_prev, c_prev, l_prev);
            after_clear = c_prev;
            tog = 8;
            clear = 1'b0;
            if (c < 400) begin
                limit = 5'd4; tog = 8;
            end else if (c < 1200) begin
                limit = 5'd16; tog = 3;
                clear = (c == 400) || ($urandom_range(149) == 0);
            end else if (c < 1300) begin
                limit = 5'd0; tog = 3; clear = (c == 1200);
            end else if (c < 1500) begin
                // flag 0 held high to saturate its total; others keep toggling (R9)
                limit = 5'd7; tog = 2; clear = (c == 1300);
            end else begin
                limit = 5'((c / 50) % 20); tog = 4;
                clear = ($urandom_range(59) == 0);
            end
            for (int i = 0; i < 3; i++) begin
                if ($urandom_range(tog - 1) == 0) flags[i] = ~flags[i];
            end
            if (c >= 1300 && c < 1500) flags[0] = 1'b1;
            rd_addr = 8'((c * 37 + c / 256) % 256);
            #1;
            compare_all();
            f_prev = flags; c_prev = clear; l_prev = int'(limit);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule